// File: doc/BRIEF.md
# Serial Audio Frame and Bit Clock Generator

This block derives the two timing clocks of a serial audio port from the master clock it runs on, for use when the port owns the clocks. The frame clock marks the left and right halves of each sample frame, and the bit clock shifts 64 data bits per frame. A 2-bit speed selector chooses single, double or quad rate, or hands clock ownership to the far end. A separate input says that the master clock runs at twice the usual ratio. In that case a divide-by-two step is added in front of both dividers, so the bit clock stays at 64 times the frame rate in every setting.

All outputs are registered levels and strobes in the master clock domain. The design provides an output enable for each clock line, a single-cycle frame-start strobe and a bit-start strobe. When the bit clock would equal the master clock, the block sets a bypass flag and the pad logic takes the master clock directly. Changes on the selector inputs are held back until the current frame ends, so the clock lines never carry a shortened pulse.

Top module: `aud_mclk_div`

## Requirements
- R1: While `rst_n` is low, every output is 0. Reset acts asynchronously. On the first clock edge after release, the block adopts the selector inputs. If they select a master setting, the first frame starts with `lrck_o` low (the left half) and `sclk_o` low.
- R2: `mode_sel` codes 2'b00, 2'b01 and 2'b10 select master operation at single, double and quad rate. In master operation `lrck_oe` and `sclk_oe` are 1. Code 2'b11 selects slave operation. In slave operation both enables are 0, and `lrck_o`, `sclk_o`, `sclk_bypass`, `bit_strobe` and `frame_start` are all 0.
- R3: With `fast_ratio` = 0, a frame lasts F = 256, 128 or 64 master cycles at single, double and quad rate. `lrck_o` is 0 for the first F/2 cycles of the frame and 1 for the last F/2 cycles.
- R4: The bit period is B = F/64 master cycles. When B >= 2, `sclk_o` is 0 for the first B/2 cycles of each bit and 1 for the rest, and `sclk_bypass` is 0. When B = 1, `sclk_o` stays 0 and `sclk_bypass` is 1.
- R5: In master operation, `lrck_o` changes only in a cycle where `sclk_o` falls, or where the bypass flag is set now or was set in the cycle before.
- R6: With `fast_ratio` = 1, the frame length F and the bit period B are both doubled for the same rate.
- R7: `frame_start` is 1 exactly in the first cycle of each frame. `bit_strobe` is 1 in the first cycle of each bit, which includes every frame start.
- R8: A change on `mode_sel` or `fast_ratio` during master operation takes effect at the first cycle of the next frame. During slave operation it takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all registers run on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Rate and ownership selector (see R2) |
| fast_ratio | input | 1 | Master clock is at the double ratio; enables the divide-by-two step |
| lrck_o | output | 1 | Frame clock level, 0 for the left half |
| lrck_oe | output | 1 | Drive enable for the frame clock line |
| sclk_o | output | 1 | Bit clock level when the bit period is two or more cycles |
| sclk_oe | output | 1 | Drive enable for the bit clock line |
| sclk_bypass | output | 1 | Bit clock equals the master clock and must be taken from it |
| bit_strobe | output | 1 | First master cycle of each bit |
| frame_start | output | 1 | First master cycle of each frame |

## Verification
The selectors are captured on a clock edge, and every output is registered from the same next-state values. As a result, each output reflects the new frame position in the cycle right after the edge that produced it, and no output lags by an extra cycle. The bench keeps its own frame position, which advances on the same rising edge, and compares all outputs at the falling edge that follows. A selector change is expected only in the cycle after the model's frame ends. The bench drives asynchronous reset at a falling edge and checks that the outputs have cleared a nanosecond later, with no clock edge in between.

// File: rtl/aud_mclk_pkg.sv
package aud_mclk_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_SLAVE  = 2'b11
  } spd_e;

  typedef struct packed {
    logic       master;
    logic [1:0] shift;
    logic       fast;
  } cfg_t;

  // Master cycles per frame for a given rate shift and prescaler setting.
  function automatic logic [31:0] frame_cycles(input logic [31:0] base,
                                               input logic [1:0]  shift,
                                               input logic        fast);
    logic [31:0] f;
    f = base >> shift;
    if (fast) f = f << 1;
    return f;
  endfunction

  // Master cycles per bit.
  function automatic logic [31:0] bit_cycles(input logic [31:0] base,
                                             input logic [31:0] bits,
                                             input logic [1:0]  shift,
                                             input logic        fast);
    return frame_cycles(base, shift, fast) / bits;
  endfunction

  // Decode of the selector pins into an active configuration.
  function automatic cfg_t decode_cfg(input logic [1:0] sel, input logic fast);
    cfg_t c;
    c.master = (sel != SPD_SLAVE);
    c.shift  = c.master ? sel : 2'b00;
    c.fast   = c.master & fast;
    return c;
  endfunction

endpackage

// File: rtl/aud_mode_latch.sv
module aud_mode_latch
  import aud_mclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       fast_ratio,
  input  logic       wrap,
  output cfg_t       cfg,
  output cfg_t       cfg_nxt
);

  always_comb begin
    cfg_nxt = wrap ? decode_cfg(mode_sel, fast_ratio) : cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg <= '0;
    else        cfg <= cfg_nxt;
  end

endmodule

// File: rtl/aud_frame_cnt.sv
module aud_frame_cnt
  import aud_mclk_pkg::*;
#(
  parameter int BASE_FRAME = 256,
  parameter int CNT_W      = $clog2(2 * BASE_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  output logic             wrap,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);

  logic [31:0] flen;

  always_comb begin
    flen    = frame_cycles(32'(BASE_FRAME), cfg.shift, cfg.fast);
    wrap    = !cfg.master || (32'(cnt) == flen - 32'd1);
    cnt_nxt = wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

endmodule

// File: rtl/aud_clk_shaper.sv
module aud_clk_shaper
  import aud_mclk_pkg::*;
#(
  parameter int BASE_FRAME = 256,
  parameter int FRAME_BITS = 64,
  parameter int CNT_W      = $clog2(2 * BASE_FRAME)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg_nxt,
  input  logic [CNT_W-1:0] cnt_nxt,
  output logic             lrck_q,
  output logic             sclk_q,
  output logic             oe_q,
  output logic             bypass_q,
  output logic             bit_q,
  output logic             frame_q
);

  logic [31:0] flen, blen, pos, phase;
  logic        lrck_d, sclk_d, bypass_d, bit_d, frame_d;

  always_comb begin
    flen     = frame_cycles(32'(BASE_FRAME), cfg_nxt.shift, cfg_nxt.fast);
    blen     = bit_cycles(32'(BASE_FRAME), 32'(FRAME_BITS), cfg_nxt.shift, cfg_nxt.fast);
    pos      = 32'(cnt_nxt);
    phase    = pos & (blen - 32'd1);
    lrck_d   = cfg_nxt.master && (pos >= (flen >> 1));
    sclk_d   = cfg_nxt.master && (blen > 32'd1) && (phase >= (blen >> 1));
    bypass_d = cfg_nxt.master && (blen == 32'd1);
    bit_d    = cfg_nxt.master && (phase == 32'd0);
    frame_d  = cfg_nxt.master && (pos == 32'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q   <= 1'b0;
      sclk_q   <= 1'b0;
      oe_q     <= 1'b0;
      bypass_q <= 1'b0;
      bit_q    <= 1'b0;
      frame_q  <= 1'b0;
    end else begin
      lrck_q   <= lrck_d;
      sclk_q   <= sclk_d;
      oe_q     <= cfg_nxt.master;
      bypass_q <= bypass_d;
      bit_q    <= bit_d;
      frame_q  <= frame_d;
    end
  end

endmodule

// File: rtl/aud_mclk_div.sv
module aud_mclk_div
  import aud_mclk_pkg::*;
#(
  parameter int BASE_FRAME = 256,
  parameter int FRAME_BITS = 64
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic       fast_ratio,
  output logic       lrck_o,
  output logic       lrck_oe,
  output logic       sclk_o,
  output logic       sclk_oe,
  output logic       sclk_bypass,
  output logic       bit_strobe,
  output logic       frame_start
);

  localparam int CNT_W = $clog2(2 * BASE_FRAME);

  cfg_t             cfg, cfg_nxt;
  logic             wrap;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             oe_q;
  logic [3:0]       cfg_word;

  assign cfg_word = cfg;

  aud_mode_latch u_latch (
    .clk        (mclk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .fast_ratio (fast_ratio),
    .wrap       (wrap),
    .cfg        (cfg),
    .cfg_nxt    (cfg_nxt)
  );

  aud_frame_cnt #(.BASE_FRAME(BASE_FRAME), .CNT_W(CNT_W)) u_cnt (
    .clk     (mclk),
    .rst_n   (rst_n),
    .cfg     (cfg),
    .wrap    (wrap),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt)
  );

  aud_clk_shaper #(.BASE_FRAME(BASE_FRAME), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)) u_shape (
    .clk      (mclk),
    .rst_n    (rst_n),
    .cfg_nxt  (cfg_nxt),
    .cnt_nxt  (cnt_nxt),
    .lrck_q   (lrck_o),
    .sclk_q   (sclk_o),
    .oe_q     (oe_q),
    .bypass_q (sclk_bypass),
    .bit_q    (bit_strobe),
    .frame_q  (frame_start)
  );

  assign lrck_oe = oe_q;
  assign sclk_oe = oe_q;

endmodule

// File: rtl/aud_mclk_div_chk.sv
module aud_mclk_div_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       lrck_o,
  input logic       lrck_oe,
  input logic       sclk_o,
  input logic       sclk_oe,
  input logic       sclk_bypass,
  input logic       bit_strobe,
  input logic       frame_start,
  input logic [3:0] cfg_word,
  input logic       wrap
);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !lrck_oe && !lrck_o && !sclk_o && !frame_start && !bit_strobe);

  p_slave_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lrck_oe |-> !lrck_o && !sclk_o && !sclk_bypass && !bit_strobe && !frame_start);

  p_oe_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lrck_oe == sclk_oe);

  p_lrck_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lrck_o) && lrck_oe && $past(lrck_oe))
      |-> ($fell(sclk_o) || sclk_bypass || $past(sclk_bypass)));

  p_frame_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bit_strobe && !lrck_o && !sclk_o);

  p_cfg_at_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> frame_start || !lrck_oe);

  p_wrap_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lrck_oe && wrap) |=> (frame_start || !lrck_oe));

endmodule

bind aud_mclk_div aud_mclk_div_chk u_chk (
  .clk         (mclk),
  .rst_n       (rst_n),
  .lrck_o      (lrck_o),
  .lrck_oe     (lrck_oe),
  .sclk_o      (sclk_o),
  .sclk_oe     (sclk_oe),
  .sclk_bypass (sclk_bypass),
  .bit_strobe  (bit_strobe),
  .frame_start (frame_start),
  .cfg_word    (cfg_word),
  .wrap        (wrap)
);

// File: tb/test_aud_mclk_div.sv
module test_aud_mclk_div;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       fast_ratio = 1'b0;
  logic       lrck_o, lrck_oe, sclk_o, sclk_oe, sclk_bypass, bit_strobe, frame_start;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #10 mclk = ~mclk;

  aud_mclk_div i_aud_mclk_div (
    .mclk        (mclk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .fast_ratio  (fast_ratio),
    .lrck_o      (lrck_o),
    .lrck_oe     (lrck_oe),
    .sclk_o      (sclk_o),
    .sclk_oe     (sclk_oe),
    .sclk_bypass (sclk_bypass),
    .bit_strobe  (bit_strobe),
    .frame_start (frame_start)
  );

  // Reference frame position, advanced on the same edge as the design.
  bit m_master = 1'b0;
  int m_shift = 0;
  bit m_fast = 1'b0;
  int m_k = 0;

  function automatic int frame_len(int shift, bit fast);
    return (256 / (1 << shift)) * (fast ? 2 : 1);
  endfunction

  always @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      m_master <= 1'b0;
      m_k      <= 0;
    end else if (!m_master || m_k == frame_len(m_shift, m_fast) - 1) begin
      m_master <= (mode_sel != 2'b11);
      m_shift  <= (mode_sel != 2'b11) ? int'(mode_sel) : 0;
      m_fast   <= (mode_sel != 2'b11) && fast_ratio;
      m_k      <= 0;
    end else begin
      m_k <= m_k + 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%b expected=%b at k=%0d t=%0t", tag, act, exp, m_k, $time);
    end
  endtask

  logic prev_lrck = 1'b0, prev_sclk = 1'b0, prev_oe = 1'b0, prev_byp = 1'b0;

  always @(negedge mclk) begin
    if (chk_en && rst_n) begin
      int f, b, ph;
      f  = frame_len(m_shift, m_fast);
      b  = f / 64;
      ph = m_k % b;
      check("R2 lrck_oe", lrck_oe, m_master);
      check("R2 sclk_oe", sclk_oe, m_master);
      check(m_fast ? "R6 lrck level" : "R3 lrck level", lrck_o, m_master && (m_k >= f / 2));
      check(m_fast ? "R6 sclk level" : "R4 sclk level", sclk_o, m_master && b > 1 && ph >= b / 2);
      check("R4 bypass", sclk_bypass, m_master && b == 1);
      check("R7 bit_strobe", bit_strobe, m_master && ph == 0);
      check("R7 frame_start", frame_start, m_master && m_k == 0);
      if (lrck_oe && prev_oe && lrck_o !== prev_lrck)
        check("R5 lrck edge on sclk fall", (prev_sclk && !sclk_o) || sclk_bypass || prev_byp, 1'b1);
      prev_lrck = lrck_o;
      prev_sclk = sclk_o;
      prev_oe   = lrck_oe;
      prev_byp  = sclk_bypass;
    end
  end

  task automatic run(input logic [1:0] m, input logic fr, input int n);
    @(negedge mclk);
    mode_sel   = m;
    fast_ratio = fr;
    repeat (n) @(negedge mclk);
  endtask

  task automatic check_all_zero(input string tag);
    check({tag, " lrck_oe"}, lrck_oe, 1'b0);
    check({tag, " lrck_o"}, lrck_o, 1'b0);
    check({tag, " sclk_o"}, sclk_o, 1'b0);
    check({tag, " frame_start"}, frame_start, 1'b0);
    check({tag, " bit_strobe"}, bit_strobe, 1'b0);
    check({tag, " bypass"}, sclk_bypass, 1'b0);
  endtask

  // Watchdog
  always @(posedge mclk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge mclk);
    check_all_zero("R1 in reset");
    // Release with single rate selected
    rst_n = 1'b1;
    chk_en = 1'b1;
    @(negedge mclk);
    check("R1 first frame start", frame_start, 1'b1);
    check("R1 first half left", lrck_o, 1'b0);
    check("R1 sclk starts low", sclk_o, 1'b0);

    // Sweep all selector codes and prescaler settings, changing mid-frame
    for (int fr = 0; fr < 2; fr++) begin
      for (int m = 0; m < 4; m++) begin
        run(2'(m), 1'(fr), 1300);
      end
    end

    // R8: request slave mid-frame, the lines stay driven until the boundary
    run(2'b00, 1'b0, 600);
    while (!frame_start) @(negedge mclk);
    repeat (10) @(negedge mclk);
    mode_sel = 2'b11;
    repeat (50) @(negedge mclk);
    check("R8 still driven mid-frame", lrck_oe, 1'b1);
    repeat (250) @(negedge mclk);
    check("R8 released after boundary", lrck_oe, 1'b0);
    // From slave a new code is adopted on the next edge
    mode_sel = 2'b10;
    @(negedge mclk);
    check("R8 slave to master at once", frame_start, 1'b1);
    run(2'b10, 1'b1, 700);

    // R1: asynchronous reset in the middle of a frame
    run(2'b00, 1'b1, 333);
    rst_n = 1'b0;
    #1;
    check_all_zero("R1 async reset");
    repeat (2) @(negedge mclk);
    check_all_zero("R1 held reset");
    rst_n = 1'b1;
    run(2'b01, 1'b0, 500);

    chk_en = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule